// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits in front of the array of a byte-wide nonvolatile memory and sees every qualified write cycle, each carrying a 13-bit address and an 8-bit data byte. It watches those writes for two keyed command sequences. One arms a persistent software write-protect mode. The other disarms it. For every write it decides whether the byte may go to the array, and it reports that decision one clock later as a commit or suppress pulse.

Out of reset, protection is off and every write goes through. A three-write key arms protection. The same key also opens a short data window, so software can update the array right after the key. The window is measured in clock cycles between accepted writes and is set by a parameter. A six-write key disarms protection. The protect register keeps its value across the window and changes only when a full key completes.

Top module: `swp_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `prot_on`, `win_open`, `wr_commit` and `wr_suppress` are all 0.
- R2: While `prot_on` is 0, every write is committed, and this includes key writes. `wr_commit` is 1 and `wr_suppress` is 0 in the cycle after the write is sampled.
- R3: The arming key is three consecutive writes: 0xAA to 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555. In the cycle after the third write is sampled, `prot_on` reads 1 and `win_open` reads 1.
- R4: Arming takes effect even if no write follows the key. `prot_on` then stays 1 through any number of idle cycles.
- R5: While `prot_on` is 1 and `win_open` is 0, every write is suppressed. Key writes are included.
- R6: A completed arming key loads a countdown with WIN_CYC, and every write accepted in the window reloads it. The countdown falls by one on each clock edge with no accepted write. A write is committed while the countdown is nonzero at the edge where the write is sampled. A write that comes WIN_CYC edges after the last load is accepted. A write that comes WIN_CYC+1 edges after it is suppressed. `win_open` shows whether the countdown is nonzero.
- R7: The disarming key is six consecutive writes: 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555. In the cycle after the sixth write, `prot_on` reads 0 and `win_open` reads 0. The following writes are committed.
- R8: A write that does not fit the partly matched key returns the matcher to idle. If that write is 0xAA@0x1555, it counts as the first step of a new key.
- R9: Writes inside an open window are treated as data, including bytes that look like key steps, and they leave the matcher idle. `prot_on` changes only in the cycle after a completed key. A completed arming key while protection is already on re-opens the window.
- R10: For each sampled write, exactly one of `wr_commit` and `wr_suppress` pulses in the next cycle. Neither pulses when no write was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | One qualified write cycle is present this clock |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data byte |
| wr_commit | output | 1 | The write sampled on the previous edge goes to the array |
| wr_suppress | output | 1 | The write sampled on the previous edge is dropped |
| prot_on | output | 1 | Software write protection is armed |
| win_open | output | 1 | The post-arm data window is open |

## Verification
The hardest cases to reach are the two edges of the data window. They need a write landing exactly WIN_CYC edges after the last reload, and another landing one edge later. The bench gets there by arming and then inserting counted idle cycles between fixed-cadence writes. Each accepted write reloads the countdown, so the same spacing can be replayed from a known starting point. Broken keys are driven with a wrong byte at a middle step, both as a plain mismatch and as 0xAA@0x1555, to show the difference between a return to idle and a restart.

// File: rtl/swp_pkg.sv
// Package: shared matcher state type, key-hit bundle and key data codes
// for the software write-protect sequencer.
package swp_pkg;

    // Key data bytes (8-bit codes).
    localparam logic [7:0] CODE_LEAD   = 8'hAA;
    localparam logic [7:0] CODE_SECOND = 8'h55;
    localparam logic [7:0] CODE_ARM    = 8'hA0;
    localparam logic [7:0] CODE_PRE    = 8'h80;
    localparam logic [7:0] CODE_DISARM = 8'h20;

    // Matcher progress through the keys.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_K1    = 3'd1,  // lead byte seen
        ST_K2    = 3'd2,  // second byte seen
        ST_K3    = 3'd3,  // pre-disarm byte seen
        ST_K4    = 3'd4,  // second lead byte seen
        ST_K5    = 3'd5   // second 0x55 seen
    } seq_st_t;

    // Which key step the current write matches.
    typedef struct packed {
        logic lead;
        logic second;
        logic arm;
        logic pre;
        logic disarm;
    } key_hit_t;

endpackage

// File: rtl/swp_key_decode.sv
// Module: swp_key_decode
// Classifies one write (address + data) against the key steps. Purely
// combinational. Assumes the data codes fit in DATA_W bits.
module swp_key_decode
    import swp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
    parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output key_hit_t          hit
);

    logic at_hi;
    logic at_lo;

    // Address compare for the two key locations.
    always_comb begin
        at_hi = (addr == ADDR_HI);
        at_lo = (addr == ADDR_LO);
    end

    // Data compare per key step.
    always_comb begin
        hit.lead   = at_hi && (data == DATA_W'(CODE_LEAD));
        hit.second = at_lo && (data == DATA_W'(CODE_SECOND));
        hit.arm    = at_hi && (data == DATA_W'(CODE_ARM));
        hit.pre    = at_hi && (data == DATA_W'(CODE_PRE));
        hit.disarm = at_hi && (data == DATA_W'(CODE_DISARM));
    end

endmodule

// File: rtl/swp_seq_fsm.sv
// Module: swp_seq_fsm
// Tracks progress through the arming and disarming keys. It advances only
// on writes (step), and returns to idle on flush (a window write). A
// mismatching write restarts at step one if it is itself the lead step.
// It pulses arm_done / disarm_done combinationally for the completing write.
module swp_seq_fsm
    import swp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    input  logic     flush,
    input  key_hit_t hit,
    output logic     arm_done,
    output logic     disarm_done
);

    seq_st_t st_q;
    seq_st_t st_d;
    seq_st_t restart;

    // Fallback state for a write that breaks the sequence.
    always_comb begin
        restart = hit.lead ? ST_K1 : ST_IDLE;
    end

    // Next-state and completion decode.
    always_comb begin
        st_d        = st_q;
        arm_done    = 1'b0;
        disarm_done = 1'b0;
        if (flush) begin
            st_d = ST_IDLE;
        end else if (step) begin
            case (st_q)
                ST_IDLE: st_d = restart;
                ST_K1:   st_d = hit.second ? ST_K2 : restart;
                ST_K2: begin
                    if (hit.arm) begin
                        st_d     = ST_IDLE;
                        arm_done = 1'b1;
                    end else if (hit.pre) begin
                        st_d = ST_K3;
                    end else begin
                        st_d = restart;
                    end
                end
                ST_K3:   st_d = hit.lead ? ST_K4 : restart;
                ST_K4:   st_d = hit.second ? ST_K5 : restart;
                ST_K5: begin
                    if (hit.disarm) begin
                        st_d        = ST_IDLE;
                        disarm_done = 1'b1;
                    end else begin
                        st_d = restart;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/swp_win_timer.sv
// Module: swp_win_timer
// Countdown for the post-arm data window. load sets it to WIN_CYC, clear
// zeroes it (clear wins), otherwise it falls by one toward zero.
// Assumes WIN_CYC >= 1.
module swp_win_timer #(
    parameter int WIN_CYC = 64,
    localparam int CNT_W  = $clog2(WIN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    output logic open
);

    logic [CNT_W-1:0] cnt_q;

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear)            cnt_q <= '0;
        else if (load)             cnt_q <= CNT_W'(WIN_CYC);
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    // Window open flag.
    always_comb begin
        open = (cnt_q != '0);
    end

endmodule

// File: rtl/swp_cmd_seq.sv
// Module: swp_cmd_seq (top)
// Software write-protect command sequencer. Each qualified write is
// decoded against the key steps, the matcher updates, and a commit or
// suppress pulse is registered for the next cycle. Protection is held in
// its own register and changes only on a completed key.
// Assumes at most one write per clock, held for exactly one cycle.
module swp_cmd_seq #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int WIN_CYC = 64,
    parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
    parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              wr_suppress,
    output logic              prot_on,
    output logic              win_open
);

    import swp_pkg::*;

    key_hit_t hit;
    logic     arm_done;
    logic     disarm_done;
    logic     win_write;
    logic     allow;
    logic     prot_q;
    logic     commit_q;
    logic     suppress_q;

    swp_key_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ADDR_HI(ADDR_HI),
        .ADDR_LO(ADDR_LO)
    ) u_dec (
        .addr(wr_addr),
        .data(wr_data),
        .hit (hit)
    );

    // Window writes are plain data and flush the matcher.
    always_comb begin
        win_write = wr_valid && win_open;
        allow     = !prot_q || win_open;
    end

    swp_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (wr_valid),
        .flush      (win_write),
        .hit        (hit),
        .arm_done   (arm_done),
        .disarm_done(disarm_done)
    );

    swp_win_timer #(
        .WIN_CYC(WIN_CYC)
    ) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .load (arm_done || win_write),
        .clear(disarm_done),
        .open (win_open)
    );

    // Protection state register.
    always_ff @(posedge clk) begin
        if (!rst_n)           prot_q <= 1'b0;
        else if (arm_done)    prot_q <= 1'b1;
        else if (disarm_done) prot_q <= 1'b0;
    end

    // Per-write decision register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q   <= 1'b0;
            suppress_q <= 1'b0;
        end else begin
            commit_q   <= wr_valid && allow;
            suppress_q <= wr_valid && !allow;
        end
    end

    // Output drive.
    always_comb begin
        prot_on     = prot_q;
        wr_commit   = commit_q;
        wr_suppress = suppress_q;
    end

endmodule

// File: rtl/swp_cmd_seq_chk.sv
// Module: swp_cmd_seq_chk
// Port-level properties of the sequencer, bound to the top module.
module swp_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic wr_commit,
    input logic wr_suppress,
    input logic prot_on,
    input logic win_open
);

    // R10
    decision_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_commit && wr_suppress));

    // R10
    decision_per_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_valid)) |-> (wr_commit || wr_suppress));

    // R10
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_valid)) |-> !(wr_commit || wr_suppress));

    // R2
    suppress_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_suppress |-> $past(prot_on));

    // R6
    window_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_on |-> !win_open);

    // R3
    arm_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> win_open);

    // R9
    prot_change_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on != $past(prot_on)) |-> $past(wr_valid));

endmodule

bind swp_cmd_seq swp_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_commit  (wr_commit),
    .wr_suppress(wr_suppress),
    .prot_on    (prot_on),
    .win_open   (win_open)
);

// File: tb/sim_swp_cmd_seq.sv
// Directed bench for swp_cmd_seq. Inputs change on the falling edge and
// outputs are sampled on the falling edge after the capturing rising edge.
module sim_swp_cmd_seq;

    localparam int WIN = 8;
    localparam logic [12:0] AH = 13'h1555;
    localparam logic [12:0] AL = 13'h0AAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_commit;
    logic        wr_suppress;
    logic        prot_on;
    logic        win_open;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    swp_cmd_seq #(.WIN_CYC(WIN)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_commit  (wr_commit),
        .wr_suppress(wr_suppress),
        .prot_on    (prot_on),
        .win_open   (win_open)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One write; check the registered decision in the next cycle.
    task automatic wr(input logic [12:0] a, input logic [7:0] d,
                      input logic exp_commit, input string req);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(req, wr_commit, exp_commit);
        chk(req, wr_suppress, !exp_commit);
    endtask

    task automatic arm(input logic exp_commit, input string req);
        wr(AH, 8'hAA, exp_commit, req);
        wr(AL, 8'h55, exp_commit, req);
        wr(AH, 8'hA0, exp_commit, req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 prot", prot_on, 1'b0);
        chk("R1 win", win_open, 1'b0);
        chk("R1 commit", wr_commit, 1'b0);
        chk("R1 suppress", wr_suppress, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prot after", prot_on, 1'b0);
        chk("R10 idle no pulse", wr_commit | wr_suppress, 1'b0);
    endtask

    task automatic t_open_writes();
        do_reset();
        wr(13'h0000, 8'h12, 1'b1, "R2 plain");
        wr(13'h1FFF, 8'hFF, 1'b1, "R2 plain top");
        wr(AH, 8'hAA, 1'b1, "R2 key committed");
        chk("R2 prot still off", prot_on, 1'b0);
    endtask

    task automatic t_arm_hold();
        do_reset();
        arm(1'b1, "R3 key while off");
        chk("R3 prot on", prot_on, 1'b1);
        chk("R3 window open", win_open, 1'b1);
        idle(40);
        chk("R4 prot held", prot_on, 1'b1);
        chk("R6 window closed", win_open, 1'b0);
        wr(13'h0123, 8'h5A, 1'b0, "R5 suppressed");
        wr(AH, 8'hAA, 1'b0, "R5 key suppressed");
    endtask

    task automatic t_window_edges();
        do_reset();
        arm(1'b1, "R6 arm");
        // k idle negedges then a write lands WIN edges after the load.
        idle(WIN - 2);
        wr(13'h0040, 8'h01, 1'b1, "R6 last edge accepted");
        idle(WIN - 2);
        wr(13'h0041, 8'h02, 1'b1, "R6 reload accepted");
        idle(WIN - 1);
        wr(13'h0042, 8'h03, 1'b0, "R6 one past suppressed");
        chk("R6 win closed", win_open, 1'b0);
        chk("R6 prot kept", prot_on, 1'b1);
    endtask

    task automatic t_window_data();
        do_reset();
        arm(1'b1, "R9 arm");
        // Key-looking bytes inside the window are data.
        wr(AH, 8'hAA, 1'b1, "R9 lead as data");
        wr(AL, 8'h55, 1'b1, "R9 second as data");
        wr(AH, 8'h80, 1'b1, "R9 pre as data");
        wr(AH, 8'hAA, 1'b1, "R9 lead as data 2");
        wr(AL, 8'h55, 1'b1, "R9 second as data 2");
        wr(AH, 8'h20, 1'b1, "R9 disarm byte as data");
        chk("R9 prot unchanged", prot_on, 1'b1);
        idle(WIN + 2);
        arm(1'b0, "R9 rearm while on");
        chk("R9 window reopened", win_open, 1'b1);
        wr(13'h0100, 8'h77, 1'b1, "R9 write after rearm");
    endtask

    task automatic t_disarm();
        do_reset();
        arm(1'b1, "R7 arm");
        idle(WIN + 2);
        wr(AH, 8'hAA, 1'b0, "R7 k1");
        wr(AL, 8'h55, 1'b0, "R7 k2");
        wr(AH, 8'h80, 1'b0, "R7 k3");
        wr(AH, 8'hAA, 1'b0, "R7 k4");
        wr(AL, 8'h55, 1'b0, "R7 k5");
        chk("R7 still on before last", prot_on, 1'b1);
        wr(AH, 8'h20, 1'b0, "R7 k6");
        chk("R7 prot off", prot_on, 1'b0);
        chk("R7 win off", win_open, 1'b0);
        wr(13'h0555, 8'h3C, 1'b1, "R7 write after disarm");
    endtask

    task automatic t_broken();
        do_reset();
        wr(AH, 8'hAA, 1'b1, "R8 s1");
        wr(AL, 8'h55, 1'b1, "R8 s2");
        wr(AH, 8'h33, 1'b1, "R8 mismatch");
        wr(AL, 8'h55, 1'b1, "R8 s2 after break");
        wr(AH, 8'hA0, 1'b1, "R8 arm after break");
        chk("R8 plain break to idle", prot_on, 1'b0);
        wr(AH, 8'hAA, 1'b1, "R8 s1b");
        wr(AL, 8'h55, 1'b1, "R8 s2b");
        wr(AH, 8'hAA, 1'b1, "R8 restart lead");
        wr(AL, 8'h55, 1'b1, "R8 s2 restarted");
        wr(AH, 8'hA0, 1'b1, "R8 arm restarted");
        chk("R8 restart arms", prot_on, 1'b1);
        idle(WIN + 2);
        wr(AH, 8'hAA, 1'b0, "R8 d1");
        wr(AL, 8'h55, 1'b0, "R8 d2");
        wr(AH, 8'h80, 1'b0, "R8 d3");
        wr(AH, 8'hAA, 1'b0, "R8 d4");
        wr(AL, 8'h99, 1'b0, "R8 d5 wrong");
        wr(AH, 8'h20, 1'b0, "R8 d6");
        chk("R8 broken disarm keeps prot", prot_on, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_open_writes();
                t_arm_hold();
                t_window_edges();
                t_window_data();
                t_disarm();
                t_broken();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule